// File: doc/BRIEF.md
# Selectable-Law Audio Sample Compressor

This block sits on the record path of an audio codec, between the converter's linear samples and the serial port. It takes one two's-complement sample per transfer and returns either the sample unchanged or an 8-bit logarithmic code word under one of the two G.711 laws, mu-law or A-law. A 2-bit law select chooses the conversion. A code word is placed in the top byte of the output word and the lower bits are zero, so the serial port can send it as the first eight bits of the frame.

Samples enter and results leave through valid/ready handshakes, with one register stage between them. A separate output tells the serial framer to use 8-bit words whenever either law is selected. The mu-law path works on the top 14 bits of the sample (sign and 13-bit magnitude). The A-law path works on the top 13 bits (sign and 12-bit magnitude). Each code word is sign, then 3-bit segment, then 4-bit step, before the law's own output inversion is applied.

Top module: `glaw_compressor`

## Requirements
- R1: A synchronous reset clears out_valid and out_data to zero.
- R2: With law_sel = 2'b00, an accepted sample appears on out_data bit for bit unchanged.
- R3: law_sel = 2'b01 is reserved and gives exactly the passthrough result of 2'b00.
- R4: With law_sel = 2'b10 (mu-law), let v be in_sample[15:2] as a signed value. The sign bit is 1 when v < 0. The magnitude |v| is limited to 8158 and then 33 is added to give b. The segment s is the leading-one position of b minus 5, and the step is b[s+4:s+1].
- R5: In mu-law, every magnitude at or above 8158 gives the same top-of-range code: 8'h80 for positive inputs and 8'h00 for negative inputs. A zero input gives 8'hFF.
- R6: With law_sel = 2'b11 (A-law), let v be in_sample[15:3] as a signed value. The sign bit is 1 when v >= 0, and the magnitude m is v for v >= 0 or -v-1 otherwise. When m < 32, the segment is 0 and the step is m[4:1]. Otherwise the segment is the leading-one position minus 4 and the step is m[s+3:s]. A zero input gives 8'hD5. The extremes give 8'hAA and 8'h2A.
- R7: The mu-law code {sign, segment, step} is inverted in all 8 bits. The A-law code is XORed with 8'h55. The result goes on out_data[15:8], and out_data[7:0] is zero.
- R8: word8 equals law_sel[1] at all times, so it is high for either law.
- R9: A sample accepted on a clock edge (in_valid and in_ready both high) is presented with out_valid high right after that edge. Results leave in the same order the samples were accepted.
- R10: While out_valid is high and out_ready is low, out_data stays fixed, out_valid stays high and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| law_sel | input | 2 | 00 passthrough, 01 reserved, 10 mu-law, 11 A-law |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | SAMPLE_W | Linear two's-complement sample |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | SAMPLE_W | Passthrough sample or code in the top byte |
| word8 | output | 1 | Requests 8-bit serial words |

## Verification
The output register is the block's only state. A wrong value in it shows up at the first handshake after the bad capture, as a code that differs from the independently computed one, or as a result out of order against the scoreboard. A stall that does not hold shows up within one cycle, as a changed out_data or a dropped out_valid while out_ready is low. The segment search is checked hardest at the segment edges and at both clip limits, where an off-by-one in the leading-one search or in the bias moves the code by one segment.

// File: rtl/glaw_compressor.sv
module glaw_compressor #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          law_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                word8
);
  localparam int MU_W   = 14;
  localparam int A_W    = 13;
  localparam int CODE_W = 8;
  localparam int PAD_W  = SAMPLE_W - CODE_W;
  localparam logic [12:0] MU_BIAS = 13'd33;
  localparam logic [13:0] MU_CLIP = 14'd8158;

  logic [MU_W-1:0] mu_lin;
  logic            mu_neg;
  logic [13:0]     mu_mag;
  logic [12:0]     mu_lim, mu_b, mu_sh;
  logic [2:0]      mu_seg;
  logic [7:0]      mu_code;

  assign mu_lin = in_sample[SAMPLE_W-1 -: MU_W];
  assign mu_neg = mu_lin[MU_W-1];
  assign mu_mag = mu_neg ? (~mu_lin + 14'd1) : mu_lin;
  assign mu_lim = (mu_mag > MU_CLIP) ? MU_CLIP[12:0] : mu_mag[12:0];
  assign mu_b   = mu_lim + MU_BIAS;

  always_comb begin
    mu_seg = '0;
    for (int i = 5; i < 13; i++)
      if (mu_b[i]) mu_seg = 3'(i - 5);
  end

  assign mu_sh   = mu_b >> ({1'b0, mu_seg} + 4'd1);
  assign mu_code = ~{mu_neg, mu_seg, mu_sh[3:0]};

  logic [A_W-1:0] a_lin;
  logic           a_pos;
  logic [11:0]    a_mag, a_sh;
  logic [2:0]     a_seg;
  logic [3:0]     a_man;
  logic [7:0]     a_code;

  assign a_lin = in_sample[SAMPLE_W-1 -: A_W];
  assign a_pos = ~a_lin[A_W-1];
  assign a_mag = a_lin[A_W-1] ? ~a_lin[11:0] : a_lin[11:0];

  always_comb begin
    a_seg = '0;
    for (int i = 5; i < 12; i++)
      if (a_mag[i]) a_seg = 3'(i - 4);
  end

  assign a_sh   = a_mag >> a_seg;
  assign a_man  = (a_seg == 3'd0) ? a_mag[4:1] : a_sh[3:0];
  assign a_code = {a_pos, a_seg, a_man} ^ 8'h55;

  logic [SAMPLE_W-1:0] result;
  always_comb begin
    case (law_sel)
      2'b10:   result = {mu_code, {PAD_W{1'b0}}};
      2'b11:   result = {a_code, {PAD_W{1'b0}}};
      default: result = in_sample;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign word8    = law_sel[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= result;
    end
  end
endmodule

module glaw_compressor_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          law_sel,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_data,
  input logic                word8
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid && out_data == '0);
  a_r8_word_mode: assert property (@(posedge clk) disable iff (rst) word8 == law_sel[1]);
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst) in_valid && in_ready |=> out_valid);
  a_r9_drain: assert property (@(posedge clk) disable iff (rst) !in_valid && out_ready |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r10_stall_ready: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |-> !in_ready);
endmodule

bind glaw_compressor glaw_compressor_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .law_sel(law_sel), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .word8(word8)
);

// File: tb/glaw_compressor_test.sv
`timescale 1ns/1ps
module glaw_compressor_test;
  logic        clk = 0, rst = 1;
  logic [1:0]  law_sel = 2'b00;
  logic        in_valid = 0, out_ready = 1;
  logic [15:0] in_sample = '0;
  logic        in_ready, out_valid, word8;
  logic [15:0] out_data;

  int checks = 0, errors = 0;
  bit bp_en = 0, done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  glaw_compressor uut (
    .clk(clk), .rst(rst), .law_sel(law_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .word8(word8)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [1:0] m, logic [15:0] s);
    int v, mag, b, seg, man;
    logic [7:0] c;
    if (m == 2'b10) begin
      v = $signed(s) >>> 2;
      mag = (v < 0) ? -v : v;
      if (mag > 8158) mag = 8158;
      b = mag + 33;
      seg = 0;
      while (seg < 7 && b >= (64 << seg)) seg++;
      man = (b >> (seg + 1)) & 15;
      c = 8'(((v < 0) ? 128 : 0) + seg * 16 + man);
      return {~c, 8'h00};
    end else if (m == 2'b11) begin
      v = $signed(s) >>> 3;
      mag = (v < 0) ? -v - 1 : v;
      if (mag < 32) begin
        seg = 0;
        man = (mag >> 1) & 15;
      end else begin
        seg = 1;
        while (seg < 7 && mag >= (32 << seg)) seg++;
        man = (mag >> seg) & 15;
      end
      c = 8'(((v >= 0) ? 128 : 0) + seg * 16 + man);
      return {c ^ 8'h55, 8'h00};
    end
    return s;
  endfunction

  task automatic send(logic [1:0] m, logic [15:0] s, logic [15:0] exp, string req);
    @(negedge clk);
    law_sel = m; in_sample = s; in_valid = 1;
    #1;
    checks++;
    if (word8 !== m[1]) begin
      errors++;
      $display("FAIL R8 actual %b expected %b", word8, m[1]);
    end
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(posedge clk);
    #1;
    in_valid = 0;
    check("R9 valid after accept", {15'd0, out_valid}, 16'd1);
  endtask

  task automatic send_m(logic [1:0] m, logic [15:0] s, string req);
    send(m, s, model(m, s), req);
  endtask

  always @(posedge clk) begin
    #1;
    if (bp_en) out_ready = ($urandom % 3) != 0;
    else out_ready = 1;
  end

  logic        held = 0;
  logic [15:0] held_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) check("R10 data held", out_data, held_data);
      if (held) check("R10 valid held", {15'd0, out_valid}, 16'd1);
      held = 0;
      if (out_valid && !out_ready) begin
        held = 1;
        held_data = out_data;
        check("R10 in_ready low", {15'd0, in_ready}, 16'd0);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected output", out_data, 16'hxxxx);
        end else begin
          check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
      end
    end else held = 0;
  end

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    check("R9 queue drained", 16'(exp_q.size()), 16'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 reset out_valid", {15'd0, out_valid}, 16'd0);
    check("R1 reset out_data", out_data, 16'd0);

    // R2 and R3 passthrough patterns
    send(2'b00, 16'hA5C3, 16'hA5C3, "R2 passthrough");
    send(2'b01, 16'h8001, 16'h8001, "R3 reserved passthrough");
    for (int i = 0; i < 60; i++) begin
      logic [15:0] s = 16'($urandom);
      send(2'b00, s, s, "R2 passthrough");
      send(2'b01, s, s, "R3 reserved passthrough");
    end

    // R4, R5, R7 mu-law directed points
    send(2'b10, 16'h0000, 16'hFF00, "R5 mu zero");
    send(2'b10, 16'h7FFF, 16'h8000, "R5 mu positive clip");
    send(2'b10, 16'h8000, 16'h0000, "R5 mu negative clip");
    send(2'b10, 16'(8158 * 4), 16'h8000, "R5 mu clip threshold");
    send(2'b10, 16'(8157 * 4), model(2'b10, 16'(8157 * 4)), "R5 mu below clip");
    for (int k = 0; k < 8; k++) begin
      int edge_v = (64 << k) - 33;
      send_m(2'b10, 16'(edge_v * 4), "R4 mu segment edge");
      send_m(2'b10, 16'((edge_v - 1) * 4), "R4 mu below edge");
      send_m(2'b10, 16'(-edge_v * 4), "R4 mu negative edge");
    end
    for (int i = 0; i < 150; i++) send_m(2'b10, 16'($urandom), "R4 mu random");

    // R6, R7 A-law
    send(2'b11, 16'h0000, 16'hD500, "R6 A zero");
    send(2'b11, 16'h7FFF, 16'hAA00, "R6 A positive max");
    send(2'b11, 16'h8000, 16'h2A00, "R6 A negative max");
    send(2'b11, 16'hFFF8, 16'h5500, "R6 A minus one");
    for (int k = 0; k < 8; k++) begin
      int edge_a = 16 << k;
      send_m(2'b11, 16'(edge_a * 8), "R6 A segment edge");
      send_m(2'b11, 16'((edge_a - 1) * 8), "R6 A below edge");
      send_m(2'b11, 16'(-edge_a * 8), "R6 A negative edge");
    end
    for (int i = 0; i < 150; i++) send_m(2'b11, 16'($urandom), "R6 A random");

    // R7 low byte zero checked through exact expected words; R10 under stalls
    bp_en = 1;
    for (int i = 0; i < 200; i++) begin
      logic [1:0] m = 2'($urandom);
      send_m(m, 16'($urandom), "R10 mixed under backpressure");
    end
    drain();

    // R1 mid-run reset with a stalled result
    bp_en = 0;
    @(posedge clk);
    #1 out_ready = 0;
    @(negedge clk);
    law_sel = 2'b00; in_sample = 16'h1234; in_valid = 1;
    @(posedge clk);
    #0.5 in_valid = 0;
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 mid-run out_valid", {15'd0, out_valid}, 16'd0);
    check("R1 mid-run out_data", out_data, 16'd0);
    send(2'b10, 16'h0000, 16'hFF00, "R1 recovery");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule